// File: doc/BRIEF.md
# Low State-of-Charge Alert Latch

This block turns a stream of integer state-of-charge readings into a sticky low-charge interrupt. A 16-bit configuration word holds a compensation byte, a sleep flag, the alert status flag and a 5-bit threshold code. A separate status word carries a power-up indicator. The threshold code is inverted: code `c` selects `(32 - c)` percent, so the range runs from 32% (code 0) down to 1% (code 31).

A reading arrives with a one-cycle update strobe. On each strobe the block compares the new reading with the one it stored on the previous strobe. If the charge moves from above the threshold to at or below it, the status flag is set and the active-low alert pin is driven low. Both stay that way until the host writes the flag back to zero. The sleep flag is only held for read-back. Nothing in the alert path looks at it.

The host writes whole 16-bit words through a simple write port that selects between the configuration and status words. Both words can be read back at all times.

Top module: `socAlertLatch`

## Requirements
- R1: After reset the configuration word reads 0x971C (compensation 0x97 in bits 15:8, sleep bit 7 = 0, alert bit 5 = 0, threshold code bits 4:0 = 0x1C, meaning 4%), the status word reads 0x0001, and the alert pin is high (released).
- R2: The threshold code in configuration bits 4:0 selects a threshold of (32 - code) percent. Code 0 gives 32% and code 0x1C gives 4%.
- R3: On a strobe where the previously stored reading is above the threshold and the new reading is at or below it, configuration bit 5 becomes 1 and the alert pin goes low, both visible right after that clock edge.
- R4: A strobe whose new reading is above the threshold does not raise the alert. A strobe whose previous reading was already at or below the threshold does not raise it either, so neither a rising crossing nor staying low fires it.
- R5: Once raised, the alert bit and the low pin stay asserted through later strobes, including readings back above the threshold, until the host writes the configuration word with bit 5 = 0.
- R6: A host write with configuration bit 5 = 1 never sets the alert bit. The other configuration fields of that write are stored.
- R7: Writing the sleep bit (configuration bit 7) to 1 neither clears the alert bit nor releases the pin.
- R8: The stored reading starts at 0xFF after reset, so the first strobe with a reading at or below the threshold raises the alert.
- R9: Status bit 0 (the reset indicator) is 1 after reset. A host write to the status word with bit 0 = 0 clears it, and a write of 1 never sets it again. All other status bits read 0.
- R10: When a crossing strobe and a host write with bit 5 = 0 land in the same cycle, the alert ends up set.
- R11: A change of the reading without a strobe is ignored. It neither raises the alert nor replaces the stored reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| socValue | input | 8 | State of charge in whole percent |
| socStrobe | input | 1 | One-cycle pulse marking a new reading |
| wrEn | input | 1 | Host write enable |
| wrSel | input | 1 | Write target: 0 = configuration word, 1 = status word |
| wrData | input | 16 | Host write data |
| alertPinN | output | 1 | Alert pin level: 0 = driven low, 1 = released |
| cfgWord | output | 16 | Configuration word read-back |
| statusWord | output | 16 | Status word read-back |

## Verification
Two kinds of internal fault show up differently at the ports. A wrong stored reading or a wrong threshold decode shows on the first strobe that crosses, or fails to cross, the boundary. The pin and bit 5 are then wrong right after that clock edge. A stuck or wrongly cleared latch shows on the next strobe or host write, when the alert bit either drops without a clearing write or fails to rise. The stimulus therefore walks the reading across the boundary at two threshold codes. It also checks the exact boundary value and the first reading after reset.

// File: rtl/socAlertPkg.sv
package socAlertPkg;
  localparam int WORD_W    = 16;
  localparam int SOC_W     = 8;
  localparam int THR_W     = 5;
  localparam int ALERT_BIT = 5;
  localparam int SLEEP_BIT = 7;
  localparam int RI_BIT    = 0;
  localparam logic [WORD_W-1:0] CFG_RESET = 16'h971C;

  typedef struct packed {
    logic cfgLoad;
    logic alertSet;
    logic socLoad;
    logic riClear;
  } ctrlStb_t;
endpackage

// File: rtl/socAlertCtrl.sv
module socAlertCtrl
  import socAlertPkg::*;
#(
  parameter int SocW = SOC_W,
  parameter int ThrW = THR_W
) (
  input  logic            socStrobe,
  input  logic [SocW-1:0] socValue,
  input  logic [SocW-1:0] prevSoc,
  input  logic [ThrW-1:0] thrCode,
  input  logic            wrEn,
  input  logic            wrSel,
  input  logic            wrRiBit,
  output ctrlStb_t        stb
);
  localparam int PctW = ThrW + 1;
  localparam logic [PctW-1:0] FULL_SPAN = PctW'(1 << ThrW);

  logic [PctW-1:0] thrPct;
  logic [SocW-1:0] thrExt;
  logic            wasAbove;
  logic            nowBelow;

  always_comb begin
    thrPct   = FULL_SPAN - {1'b0, thrCode};
    thrExt   = SocW'(thrPct);
    wasAbove = prevSoc > thrExt;
    nowBelow = socValue <= thrExt;
    stb.socLoad  = socStrobe;
    stb.alertSet = socStrobe && wasAbove && nowBelow;
    stb.cfgLoad  = wrEn && !wrSel;
    stb.riClear  = wrEn && wrSel && !wrRiBit;
  end
endmodule

// File: rtl/socAlertDp.sv
module socAlertDp
  import socAlertPkg::*;
#(
  parameter int SocW  = SOC_W,
  parameter int ThrW  = THR_W,
  parameter int WordW = WORD_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  logic [SocW-1:0]  socValue,
  input  logic [WordW-1:0] wrData,
  output logic [SocW-1:0]  prevSoc,
  output logic [ThrW-1:0]  thrCode,
  output logic             alertPinN,
  output logic [WordW-1:0] cfgWord,
  output logic [WordW-1:0] statusWord
);
  localparam logic [SocW-1:0] SOC_START = '1;

  logic [WordW-1:0] cfgReg, cfgNext;
  logic [SocW-1:0]  socReg;
  logic             riReg;

  always_comb begin
    cfgNext = cfgReg;
    if (stb.cfgLoad) begin
      cfgNext = wrData;
      cfgNext[ALERT_BIT] = cfgReg[ALERT_BIT] & wrData[ALERT_BIT];
    end
    if (stb.alertSet) cfgNext[ALERT_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= CFG_RESET;
      socReg <= SOC_START;
      riReg  <= 1'b1;
    end else begin
      cfgReg <= cfgNext;
      if (stb.socLoad) socReg <= socValue;
      if (stb.riClear) riReg <= 1'b0;
    end
  end

  always_comb begin
    prevSoc    = socReg;
    thrCode    = cfgReg[ThrW-1:0];
    alertPinN  = ~cfgReg[ALERT_BIT];
    cfgWord    = cfgReg;
    statusWord = '0;
    statusWord[RI_BIT] = riReg;
  end
endmodule

// File: rtl/socAlertLatch.sv
module socAlertLatch
  import socAlertPkg::*;
#(
  parameter int SocW  = SOC_W,
  parameter int ThrW  = THR_W,
  parameter int WordW = WORD_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SocW-1:0]  socValue,
  input  logic             socStrobe,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [WordW-1:0] wrData,
  output logic             alertPinN,
  output logic [WordW-1:0] cfgWord,
  output logic [WordW-1:0] statusWord
);
  ctrlStb_t        stb;
  logic [SocW-1:0] prevSoc;
  logic [ThrW-1:0] thrCode;

  socAlertCtrl #(.SocW(SocW), .ThrW(ThrW)) i_ctrl (
    .socStrobe (socStrobe),
    .socValue  (socValue),
    .prevSoc   (prevSoc),
    .thrCode   (thrCode),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .wrRiBit   (wrData[RI_BIT]),
    .stb       (stb)
  );

  socAlertDp #(.SocW(SocW), .ThrW(ThrW), .WordW(WordW)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .socValue   (socValue),
    .wrData     (wrData),
    .prevSoc    (prevSoc),
    .thrCode    (thrCode),
    .alertPinN  (alertPinN),
    .cfgWord    (cfgWord),
    .statusWord (statusWord)
  );
endmodule

// File: rtl/socAlertChk.sv
module socAlertChk
  import socAlertPkg::*;
#(
  parameter int SocW  = SOC_W,
  parameter int ThrW  = THR_W,
  parameter int WordW = WORD_W
) (
  input logic             clk,
  input logic             rstN,
  input logic [SocW-1:0]  socValue,
  input logic             socStrobe,
  input logic             wrEn,
  input logic             wrSel,
  input logic [WordW-1:0] wrData,
  input logic             alertPinN,
  input logic [WordW-1:0] cfgWord,
  input logic [WordW-1:0] statusWord
);
  localparam logic [SocW-1:0] SPAN = SocW'(1 << ThrW);

  logic [SocW-1:0] thrNow;
  logic            hostClear;
  assign thrNow    = SPAN - SocW'(cfgWord[ThrW-1:0]);
  assign hostClear = wrEn && !wrSel && !wrData[ALERT_BIT];

  // R3
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgWord[ALERT_BIT]) |-> $past(socStrobe) && ($past(socValue) <= $past(thrNow)));

  // R5
  alert_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWord[ALERT_BIT] && !hostClear) |=> cfgWord[ALERT_BIT] && !alertPinN);

  // R6
  no_host_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWord[ALERT_BIT] && !socStrobe) |=> !cfgWord[ALERT_BIT]);

  // R9
  ri_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !statusWord[RI_BIT] |=> !statusWord[RI_BIT]);

  // R11
  soc_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !socStrobe |=> !$rose(cfgWord[ALERT_BIT]));
endmodule

bind socAlertLatch socAlertChk #(.SocW(SocW), .ThrW(ThrW), .WordW(WordW)) i_socAlertChk (
  .clk        (clk),
  .rstN       (rstN),
  .socValue   (socValue),
  .socStrobe  (socStrobe),
  .wrEn       (wrEn),
  .wrSel      (wrSel),
  .wrData     (wrData),
  .alertPinN  (alertPinN),
  .cfgWord    (cfgWord),
  .statusWord (statusWord)
);

// File: tb/test_socAlertLatch.sv
module test_socAlertLatch;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct {
    logic [15:0] cfg;
    logic [15:0] stat;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  socValue = '0;
  logic        socStrobe = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [15:0] wrData = '0;
  logic        alertPinN;
  logic [15:0] cfgWord, statusWord;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  socAlertLatch i_socAlertLatch (
    .clk(clk), .rstN(rstN), .socValue(socValue), .socStrobe(socStrobe),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .alertPinN(alertPinN), .cfgWord(cfgWord), .statusWord(statusWord)
  );

  // monitor: compares one queued item per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (cfgWord !== e.cfg || statusWord !== e.stat || alertPinN !== ~e.cfg[5]) begin
          errors++;
          $display("FAIL %s: cfg=%h stat=%h pin=%b expected cfg=%h stat=%h pin=%b",
                   e.tag, cfgWord, statusWord, alertPinN, e.cfg, e.stat, ~e.cfg[5]);
        end
      end
    end
  end

  task automatic doOp(input logic stbIn, input logic [7:0] soc, input logic wr,
                      input logic sel, input logic [15:0] data,
                      input logic [15:0] expCfg, input logic [15:0] expStat, input string tag);
    @(negedge clk);
    socStrobe = stbIn; socValue = soc; wrEn = wr; wrSel = sel; wrData = data;
    @(posedge clk);
    #1;
    socStrobe = 1'b0; wrEn = 1'b0;
    expQ.push_back('{cfg: expCfg, stat: expStat, tag: tag});
  endtask

  task automatic strobe(input logic [7:0] soc, input logic [15:0] expCfg,
                        input logic [15:0] expStat, input string tag);
    doOp(1'b1, soc, 1'b0, 1'b0, 16'h0, expCfg, expStat, tag);
  endtask

  task automatic wcfg(input logic [15:0] d, input logic [15:0] expCfg,
                      input logic [15:0] expStat, input string tag);
    doOp(1'b0, 8'd0, 1'b1, 1'b0, d, expCfg, expStat, tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    doReset();
    doOp(1'b0, 8'd0, 1'b0, 1'b0, 16'h0, 16'h971C, 16'h0001, "R1 reset values");
    strobe(8'd50, 16'h971C, 16'h0001, "R4 reading above threshold");
    strobe(8'd5,  16'h971C, 16'h0001, "R2 5% above 4% threshold");
    strobe(8'd4,  16'h973C, 16'h0001, "R3 crossing to exactly 4%");
    strobe(8'd3,  16'h973C, 16'h0001, "R4 staying low no refire");
    strobe(8'd80, 16'h973C, 16'h0001, "R5 latched after recovery");
    wcfg(16'h97BC, 16'h97BC, 16'h0001, "R7 sleep keeps alert");
    wcfg(16'h971C, 16'h971C, 16'h0001, "R5 host clear");
    wcfg(16'h9700, 16'h9700, 16'h0001, "R2 code 0 stored");
    strobe(8'd33, 16'h9700, 16'h0001, "R2 33% above 32%");
    strobe(8'd32, 16'h9720, 16'h0001, "R2 crossing at 32%");
    wcfg(16'h4A05, 16'h4A05, 16'h0001, "R5 clear with new fields");
    wcfg(16'h4A25, 16'h4A05, 16'h0001, "R6 host write of 1 ignored");
    strobe(8'd40, 16'h4A05, 16'h0001, "R4 above 27%");
    doOp(1'b0, 8'd10, 1'b0, 1'b0, 16'h0, 16'h4A05, 16'h0001, "R11 no strobe");
    strobe(8'd27, 16'h4A25, 16'h0001, "R11 stored stays 40, R3 crossing 27%");
    strobe(8'd50, 16'h4A25, 16'h0001, "R5 latched");
    wcfg(16'h4A05, 16'h4A05, 16'h0001, "R5 clear again");
    doOp(1'b1, 8'd20, 1'b1, 1'b0, 16'h4A05, 16'h4A25, 16'h0001, "R10 set beats clear");
    doOp(1'b0, 8'd0, 1'b1, 1'b1, 16'h0001, 16'h4A25, 16'h0001, "R9 write 1 keeps");
    doOp(1'b0, 8'd0, 1'b1, 1'b1, 16'hFFFE, 16'h4A25, 16'h0000, "R9 clear indicator");
    doOp(1'b0, 8'd0, 1'b1, 1'b1, 16'hFFFF, 16'h4A25, 16'h0000, "R9 no re-set");
    doReset();
    doOp(1'b0, 8'd0, 1'b0, 1'b0, 16'h0, 16'h971C, 16'h0001, "R1 reset values again");
    strobe(8'd2,  16'h973C, 16'h0001, "R8 first reading fires");
    wcfg(16'h971C, 16'h971C, 16'h0001, "R5 clear");
    strobe(8'd1,  16'h971C, 16'h0001, "R4 already low no fire");
    strobe(8'd10, 16'h971C, 16'h0001, "R4 rising crossing no fire");
    strobe(8'd3,  16'h973C, 16'h0001, "R3 fresh crossing");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule